// File: doc/BRIEF.md
# Programmable Polynomial Audio Waveform Generator

This block turns a 4-bit mode word into a one-bit audio waveform. Inside it sit a 5-bit and a 4-bit polynomial shift register, a set of small modulo counters, and a decoder that maps each mode code to two things: how the 4-bit register advances, and which internal source drives the output. In one mode the two registers are joined into a single 9-bit register, which gives a long noise sequence. Other modes give square waves, asymmetric tones, sequences gated by the 5-bit register, or a 4-bit polynomial that is stepped at a slow rate.

The block moves forward by one step on each cycle in which `step_en` is high. An upstream rate divider supplies that pulse. The mode word is loaded through a write strobe and is used from the next step onward. Loading a mode never clears the shift registers or the counters. The output is registered and changes only when a step is taken.

Top module: `aud_wave_gen`

## Requirements
- R1: Synchronous active-high reset forces `wave_o` low. It also loads mode 0000 and gives both polynomial registers a non-zero seed. With mode 0000 kept, later steps leave `wave_o` low.
- R2: `wave_o` changes only on a cycle with `step_en` high. A mode written while `step_en` is low leaves `wave_o` unchanged until the next step. That next step uses the new mode.
- R3: Mode codes 0000 and 1011 hold `wave_o` at 0 on every step. The pattern period is 1.
- R4: Mode 0001 steps the bare 4-bit polynomial on every step. The output repeats every 15 steps as a rotation of 000011101100101, with 7 high steps.
- R5: Codes 0100 and 0101 give a square wave of period 2 with 1 high step. Codes 1100 and 1101 give period 6: 3 low steps, then 3 high steps.
- R6: Codes 0110 and 1010 give a tone of period 31 with 13 low and 18 high steps. Code 1110 gives period 93 with 44 low and 49 high steps.
- R7: Code 1001 outputs the 5-bit polynomial, with period 31 and 16 high steps. Code 0111 outputs a toggle that flips on each step where the 5-bit output is 1, with period 31.
- R8: Code 1000 chains the 5-bit and 4-bit registers into one 9-bit polynomial. It gives noise with period 511 and 256 high steps.
- R9: Code 0010 advances the 4-bit polynomial once per 31 steps, giving period 465 with 217 high steps. Code 0011 advances it on steps where the 5-bit output is 1, giving period 465. Code 1111 advances a divide-by-6 on those same steps, giving period 93.
- R10: The 4-bit register holds its state in modes that do not use it, so a later return to 0001 continues the sequence where it stopped. The combined 9-bit state is never all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance pulse from the upstream rate divider |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_in | input | 4 | Mode word, bit 3 down to bit 0 |
| wave_o | output | 1 | Registered one-bit waveform |

## Verification
All sixteen mode codes are run in turn. For each one, twice its period is captured. The capture is then compared against itself shifted by the required period, and against every shorter divisor of that period. This tells a correct sequence length apart from a shorter loop. High-step counts separate duty ratios that share one period, for example the 13/18 tone versus the 5-bit polynomial.

Mode 0001 is matched against its fixed pattern under every rotation. Directed runs cover three more cases. A mode written with no step taken shows that writes wait for the next step. A detour through modes that leave the 4-bit register idle shows that its sequence resumes exactly. A reset in the middle of a run shows the output forced low.

// File: rtl/aud_wave_pkg.sv
package aud_wave_pkg;

    localparam int MODE_W = 4;
    localparam int P4_W   = 4;
    localparam int P5_W   = 5;
    localparam int P9_W   = P4_W + P5_W;

    localparam logic [P4_W-1:0] P4_SEED = 4'b0001;
    localparam logic [P5_W-1:0] P5_SEED = 5'b00001;

    // how the 4-bit register moves on a step
    typedef enum logic [2:0] {
        P4_HOLD,
        P4_EVERY,
        P4_DIV31,
        P4_P5GATE,
        P4_CHAIN
    } p4_adv_e;

    // which source drives the waveform
    typedef enum logic [3:0] {
        SEL_LOW,
        SEL_P4,
        SEL_P5,
        SEL_P9,
        SEL_SQ2,
        SEL_DIV6,
        SEL_DIV31,
        SEL_DIV93,
        SEL_P5TOG,
        SEL_P5DIV6
    } out_sel_e;

    typedef struct packed {
        p4_adv_e  p4_adv;
        out_sel_e out_sel;
    } mode_ctl_t;

    // counter slots in the tone bank
    localparam int CNT_N      = 6;
    localparam int CI_SQ2     = 0;
    localparam int CI_DIV6    = 1;
    localparam int CI_DIV31   = 2;
    localparam int CI_DIV93   = 3;
    localparam int CI_P5TOG   = 4;
    localparam int CI_P5DIV6  = 5;

    function automatic mode_ctl_t decode_mode(input logic [MODE_W-1:0] m);
        mode_ctl_t c;
        c.p4_adv  = P4_HOLD;
        c.out_sel = SEL_LOW;
        case (m)
            4'b0000, 4'b1011: c.out_sel = SEL_LOW;
            4'b0001: begin c.out_sel = SEL_P4; c.p4_adv = P4_EVERY;  end
            4'b0010: begin c.out_sel = SEL_P4; c.p4_adv = P4_DIV31;  end
            4'b0011: begin c.out_sel = SEL_P4; c.p4_adv = P4_P5GATE; end
            4'b0100, 4'b0101: c.out_sel = SEL_SQ2;
            4'b0110, 4'b1010: c.out_sel = SEL_DIV31;
            4'b0111: c.out_sel = SEL_P5TOG;
            4'b1000: begin c.out_sel = SEL_P9; c.p4_adv = P4_CHAIN; end
            4'b1001: c.out_sel = SEL_P5;
            4'b1100, 4'b1101: c.out_sel = SEL_DIV6;
            4'b1110: c.out_sel = SEL_DIV93;
            default: c.out_sel = SEL_P5DIV6;
        endcase
        return c;
    endfunction

    // x^5 + x^2 + 1, with a one-bit injection out of all-zero
    function automatic logic [P5_W-1:0] p5_next(input logic [P5_W-1:0] s);
        return {(s[0] ^ s[2]) | (s == '0), s[P5_W-1:1]};
    endfunction

    // x^4 + x + 1, with a one-bit injection out of all-zero
    function automatic logic [P4_W-1:0] p4_next(input logic [P4_W-1:0] s);
        return {(s[0] ^ s[1]) | (s == '0), s[P4_W-1:1]};
    endfunction

endpackage

// File: rtl/aud_mode_reg.sv
module aud_mode_reg
    import aud_wave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MODE_W-1:0] mode_in,
    output mode_ctl_t         ctl
);

    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst)     mode_q <= '0;
        else if (we) mode_q <= mode_in;
    end

    always_comb ctl = decode_mode(mode_q);

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mode_q == $past(mode_in)));

endmodule

// File: rtl/aud_mod_counter.sv
module aud_mod_counter #(
    parameter int MOD = 6,
    parameter int LOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic hi,
    output logic wrap
);

    localparam int CW = (MOD > 2) ? $clog2(MOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(MOD - 1);
    localparam logic [CW-1:0] THR  = CW'(LOW);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (en)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign hi   = (cnt_q >= THR);
    assign wrap = en && (cnt_q == LAST);

endmodule

// File: rtl/aud_poly_core.sv
module aud_poly_core
    import aud_wave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  p4_adv_e adv,
    input  logic    slow_tick,
    output logic    p4_bit,
    output logic    p5_bit
);

    logic [P4_W-1:0] p4_q, p4_d;
    logic [P5_W-1:0] p5_q, p5_d;
    logic            fb9;
    logic            p4_go;

    // 9-bit chain: x^9 + x^4 + 1 over {p4, p5}
    assign fb9 = (p5_q[0] ^ p5_q[4]) | ({p4_q, p5_q} == '0);

    always_comb begin
        case (adv)
            P4_EVERY:  p4_go = 1'b1;
            P4_DIV31:  p4_go = slow_tick;
            P4_P5GATE: p4_go = p5_q[0];
            default:   p4_go = 1'b0;
        endcase
    end

    always_comb begin
        p4_d = p4_q;
        p5_d = p5_q;
        if (step) begin
            if (adv == P4_CHAIN) begin
                p5_d = {p4_q[0], p5_q[P5_W-1:1]};
                p4_d = {fb9, p4_q[P4_W-1:1]};
            end else begin
                p5_d = p5_next(p5_q);
                if (p4_go) p4_d = p4_next(p4_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p4_q <= P4_SEED;
            p5_q <= P5_SEED;
        end else begin
            p4_q <= p4_d;
            p5_q <= p5_d;
        end
    end

    assign p4_bit = p4_q[0];
    assign p5_bit = p5_q[0];

    // R10
    state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        ({p4_q, p5_q} != '0));

    // R10
    p4_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && adv == P4_HOLD) |=> $stable(p4_q));

endmodule

// File: rtl/aud_wave_gen.sv
module aud_wave_gen
    import aud_wave_pkg::*;
#(
    parameter int SHORT_MOD = 6,
    parameter int SHORT_LOW = 3,
    parameter int MID_MOD   = 31,
    parameter int MID_LOW   = 13,
    parameter int LONG_MOD  = 93,
    parameter int LONG_LOW  = 44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    output logic              wave_o
);

    localparam int       MODS  [CNT_N] = '{2, SHORT_MOD, MID_MOD, LONG_MOD, 2, SHORT_MOD};
    localparam int       LOWS  [CNT_N] = '{1, SHORT_LOW, MID_LOW, LONG_LOW, 1, SHORT_LOW};
    localparam bit       GATED [CNT_N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    mode_ctl_t          ctl;
    logic               p4_bit, p5_bit;
    logic [CNT_N-1:0]   cnt_hi, cnt_wrap, cnt_en;
    logic               wave_d;

    aud_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .we      (mode_we),
        .mode_in (mode_in),
        .ctl     (ctl)
    );

    aud_poly_core u_poly (
        .clk       (clk),
        .rst       (rst),
        .step      (step_en),
        .adv       (ctl.p4_adv),
        .slow_tick (cnt_wrap[CI_DIV31]),
        .p4_bit    (p4_bit),
        .p5_bit    (p5_bit)
    );

    for (genvar k = 0; k < CNT_N; k++) begin : g_cnt
        assign cnt_en[k] = step_en && (GATED[k] ? p5_bit : 1'b1);
        aud_mod_counter #(
            .MOD (MODS[k]),
            .LOW (LOWS[k])
        ) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .en   (cnt_en[k]),
            .hi   (cnt_hi[k]),
            .wrap (cnt_wrap[k])
        );
    end

    always_comb begin
        case (ctl.out_sel)
            SEL_P4:     wave_d = ~p4_bit;
            SEL_P5,
            SEL_P9:     wave_d = p5_bit;
            SEL_SQ2:    wave_d = cnt_hi[CI_SQ2];
            SEL_DIV6:   wave_d = cnt_hi[CI_DIV6];
            SEL_DIV31:  wave_d = cnt_hi[CI_DIV31];
            SEL_DIV93:  wave_d = cnt_hi[CI_DIV93];
            SEL_P5TOG:  wave_d = cnt_hi[CI_P5TOG];
            SEL_P5DIV6: wave_d = cnt_hi[CI_P5DIV6];
            default:    wave_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          wave_o <= 1'b0;
        else if (step_en) wave_o <= wave_d;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !wave_o);

    // R2
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(wave_o));

    // R3
    const_low_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && ctl.out_sel == SEL_LOW) |=> !wave_o);

endmodule

// File: tb/tb_aud_wave_gen.sv
`timescale 1ns/1ps
module tb_aud_wave_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_in = 4'b0000;
    logic       wave_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // period and high-step count per mode code (index = code); -1 skips the count
    localparam int PER  [16] = '{1, 15, 465, 465, 2, 2, 31, 31, 511, 31, 31, 1, 6, 6, 93, 93};
    localparam int ONES [16] = '{0, 7, 217, -1, 1, 1, 18, -1, 256, 16, 18, 0, 3, 3, 49, -1};
    localparam logic [14:0] PAT4 = 15'b000011101100101;

    logic smp [0:1023];

    always #4 clk = ~clk;

    aud_wave_gen dut (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .mode_we (mode_we),
        .mode_in (mode_in),
        .wave_o  (wave_o)
    );

    function automatic string req_of(input int m);
        case (m)
            0, 11:            return "R3";
            1:                return "R4";
            4, 5, 12, 13:     return "R5";
            6, 10, 14:        return "R6";
            7, 9:             return "R7";
            8:                return "R8";
            default:          return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_step(output logic v);
        @(negedge clk) step_en = 1'b1;
        @(negedge clk) step_en = 1'b0;
        v = wave_o;
    endtask

    task automatic write_mode(input logic [3:0] m);
        @(negedge clk) begin mode_we = 1'b1; mode_in = m; end
        @(negedge clk) mode_we = 1'b0;
    endtask

    function automatic logic pat_at(input int i);
        return PAT4[14 - (i % 15)];
    endfunction

    initial begin
        logic v;
        int   rot;
        logic first5 [5];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(wave_o == 1'b0, "R1", "output after reset", wave_o, 0);
        for (int i = 0; i < 4; i++) begin
            do_step(v);
            check(v == 1'b0, "R1", "default mode output", v, 0);
        end

        // table walk over all mode codes
        for (int m = 0; m < 16; m++) begin
            int p;
            int ones;
            bit per_ok;
            bit min_ok;
            p = PER[m];
            write_mode(m[3:0]);
            for (int w = 0; w < 8; w++) do_step(v);
            for (int n = 0; n < 2 * p; n++) do_step(smp[n]);
            per_ok = 1'b1;
            ones = 0;
            for (int n = 0; n < p; n++) begin
                if (smp[n] != smp[n + p]) per_ok = 1'b0;
                if (smp[n]) ones++;
            end
            check(per_ok, req_of(m), $sformatf("mode %0d repeats", m), per_ok, 1);
            if (ONES[m] >= 0)
                check(ones == ONES[m], req_of(m), $sformatf("mode %0d high steps", m),
                      ones, ONES[m]);
            if (p > 1) begin
                min_ok = 1'b1;
                for (int s = 1; s < p; s++) begin
                    if (p % s == 0) begin
                        bit diff;
                        diff = 1'b0;
                        for (int n = 0; n < p; n++)
                            if (smp[n] != smp[n + s]) diff = 1'b1;
                        if (!diff) min_ok = 1'b0;
                    end
                end
                check(min_ok, req_of(m), $sformatf("mode %0d no shorter period", m),
                      min_ok, 1);
            end
            if (m == 1) begin
                bit any;
                any = 1'b0;
                for (int r = 0; r < 15; r++) begin
                    bit okr;
                    okr = 1'b1;
                    for (int n = 0; n < 15; n++)
                        if (smp[n] != pat_at(r + n)) okr = 1'b0;
                    if (okr) any = 1'b1;
                end
                check(any, "R4", "pattern match under rotation", any, 1);
            end
        end

        // R2: mode write waits for a step
        write_mode(4'b0100);
        do_step(v);
        if (v == 1'b0) do_step(v);
        check(v == 1'b1, "R2", "square high before write", v, 1);
        write_mode(4'b0000);
        repeat (5) begin
            @(negedge clk);
            check(wave_o == 1'b1, "R2", "held without step", wave_o, 1);
        end
        do_step(v);
        check(v == 1'b0, "R2", "new mode on next step", v, 0);

        // R10: 4-bit sequence resumes after modes that leave it idle
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        write_mode(4'b0001);
        for (int i = 0; i < 5; i++) do_step(first5[i]);
        rot = -1;
        for (int r = 0; r < 15; r++) begin
            bit okr;
            okr = 1'b1;
            for (int i = 0; i < 5; i++) if (first5[i] != pat_at(r + i)) okr = 1'b0;
            if (okr && rot < 0) rot = r;
        end
        check(rot >= 0, "R4", "start window found", rot, 0);
        if (rot < 0) rot = 0;
        write_mode(4'b0101);
        repeat (7) do_step(v);
        write_mode(4'b1001);
        repeat (3) do_step(v);
        write_mode(4'b0001);
        for (int i = 0; i < 10; i++) begin
            do_step(v);
            check(v == pat_at(rot + 5 + i), "R10", $sformatf("resume step %0d", i),
                  v, pat_at(rot + 5 + i));
        end

        // R1: reset in the middle of a run
        write_mode(4'b0100);
        do_step(v);
        if (v == 1'b0) do_step(v);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check(wave_o == 1'b0, "R1", "mid-run reset low", wave_o, 0);
        do_step(v);
        check(v == 1'b0, "R1", "mode back to 0000", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule